// File: doc/BRIEF.md
# Single-bit NAND ECC checker

This block decides what to do with a 512-byte NAND chunk protected by a one-bit-correcting parity code. Each code is 24 bits wide. It is built from two 12-bit parity halves, and the upper half locates the failing bit. The block takes the code that was stored in the spare area and the code that was recomputed while the chunk was read back. When the caller raises a strobe, the block XORs the two codes and classifies the difference. One clock later it reports one of four outcomes: clean, one data bit to flip, a fault in the stored code only, or uncorrectable. For a data-bit fault it also gives the byte index and the bit index within that byte.

A combinational helper path turns a raw 32-bit parity register value into the 24-bit code. It takes the two 12-bit fields and inverts the result, so a fully erased chunk checks as valid. The per-byte parity accumulator and the data buffer sit outside the block.

Top module: `ecc1_check`

## Requirements
- R1: `packed_code` equals the bitwise inverse of {`raw_parity[27:16]`, `raw_parity[11:0]`}. The upper raw field becomes code bits 23:12 and the lower raw field becomes code bits 11:0.
- R2: When `stored_code` equals `calc_code`, the reported status is 0 (clean).
- R3: Let d be `stored_code ^ calc_code`. If d[23:12] XOR d[11:0] equals 12'hFFF and d[23:15] is below `CHUNK_BYTES`, status is 1 (data bit corrected), `err_byte` = d[23:15] and `err_bit` = d[14:12].
- R4: If the halves of d are complements as in R3 but d[23:15] is not below `CHUNK_BYTES`, status is 3 (uncorrectable).
- R5: If d is nonzero, its halves are not complements, and exactly one bit of d is set, status is 2 (fault in the stored code only, no data change).
- R6: Every other nonzero d gives status 3.
- R7: `out_valid` is high for exactly the one cycle after each cycle in which `in_valid` is high, and low otherwise.
- R8: `status`, `err_byte` and `err_bit` keep their values in every cycle without a strobe, whatever the code inputs do.
- R9: A low `rst_n` at a clock edge clears `out_valid`, `status`, `err_byte` and `err_bit` to zero.
- R10: Whenever status is not 1, `err_byte` and `err_bit` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: compare the two codes this cycle |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code recomputed over the data just read |
| raw_parity | input | 32 | Raw parity register value for the packing helper |
| packed_code | output | 24 | Inverted 24-bit code built from `raw_parity` |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| status | output | 2 | 0 clean, 1 data bit corrected, 2 code-only fault, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the bit to flip |
| err_bit | output | 3 | Bit index within that byte |

## Verification
The bench keeps the 12-bit half width but sets `CHUNK_BYTES` to 384. With that setting, the upper quarter of the 9-bit byte-index range becomes reachable, and those positions must be rejected as uncorrectable. The bench sweeps every byte and bit position through the complementary-difference pattern, which covers both the correctable and the out-of-range outcome. It also injects every single-bit and every two-bit difference over a varying base code. Throughout, it checks that results hold between strobes and are cleared by reset.

// File: rtl/ecc1_pkg.sv
// Package: shared outcome encoding for the single-bit ECC checker.
// Assumes a 2-bit status bus; the values are part of the port contract.
package ecc1_pkg;
    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIXED    = 2'd1,
        ST_ECC_ONLY = 2'd2,
        ST_FATAL    = 2'd3
    } ecc1_status_e;
endpackage

// File: rtl/ecc1_pack.sv
// ecc1_pack: builds the stored-format code from a raw parity register.
// Takes two HALF_W-bit fields (at bit 0 and at HI_LSB) and inverts the
// concatenation so that erased (all-ones) data yields a matching code.
// Assumes HI_LSB >= HALF_W and HI_LSB + HALF_W <= RAW_W.
module ecc1_pack #(
    parameter int HALF_W = 12,
    parameter int RAW_W  = 32,
    parameter int HI_LSB = 16
) (
    input  logic [RAW_W-1:0]    raw,
    output logic [2*HALF_W-1:0] code
);
    logic [HALF_W-1:0] lo_field;
    logic [HALF_W-1:0] hi_field;

    // Field extraction and inversion.
    always_comb begin
        lo_field = raw[HALF_W-1:0];
        hi_field = raw[HI_LSB +: HALF_W];
        code     = ~{hi_field, lo_field};
    end
endmodule

// File: rtl/ecc1_classify.sv
// ecc1_classify: combinational decoder of a parity difference word.
// Complementary halves locate one data bit; a lone set bit elsewhere is a
// fault in the stored code; anything else cannot be repaired.
// Assumes HALF_W > 3 so that a byte index exists above the bit index.
module ecc1_classify
    import ecc1_pkg::*;
#(
    parameter int HALF_W      = 12,
    parameter int CHUNK_BYTES = 512
) (
    input  logic [2*HALF_W-1:0]  diff,
    output ecc1_status_e         kind,
    output logic [HALF_W-4:0]    byte_idx,
    output logic [2:0]           bit_idx
);
    localparam int BYTE_W = HALF_W - 3;
    localparam logic [BYTE_W:0] CHUNK_LIM = CHUNK_BYTES[BYTE_W:0];

    logic [HALF_W-1:0] hi_half;
    logic [HALF_W-1:0] lo_half;
    logic              is_zero;
    logic              is_compl;
    logic              is_single;
    logic              in_range;
    logic [BYTE_W-1:0] pos_byte;
    logic [2:0]        pos_bit;

    // Feature extraction from the difference word.
    always_comb begin
        hi_half   = diff[2*HALF_W-1:HALF_W];
        lo_half   = diff[HALF_W-1:0];
        is_zero   = (diff == '0);
        is_compl  = ((hi_half ^ lo_half) == '1);
        is_single = !is_zero && ((diff & (diff - 1'b1)) == '0);
        pos_byte  = hi_half[HALF_W-1:3];
        pos_bit   = hi_half[2:0];
        in_range  = ({1'b0, pos_byte} < CHUNK_LIM);
    end

    // Outcome selection; positions only reported for a data-bit repair.
    always_comb begin
        kind     = ST_FATAL;
        byte_idx = '0;
        bit_idx  = '0;
        if (is_zero) begin
            kind = ST_CLEAN;
        end else if (is_compl) begin
            if (in_range) begin
                kind     = ST_FIXED;
                byte_idx = pos_byte;
                bit_idx  = pos_bit;
            end
        end else if (is_single) begin
            kind = ST_ECC_ONLY;
        end
    end
endmodule

// File: rtl/ecc1_result_reg.sv
// ecc1_result_reg: captures a classification on the strobe and holds it.
// Raises a one-cycle valid pulse after each strobe; synchronous active-low
// reset clears every output.
module ecc1_result_reg
    import ecc1_pkg::*;
#(
    parameter int BYTE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  ecc1_status_e      kind_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [2:0]        bit_in,
    output logic              valid_q,
    output ecc1_status_e      kind_q,
    output logic [BYTE_W-1:0] byte_q,
    output logic [2:0]        bit_q
);
    // Valid pulse follows each strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= load;
    end

    // Result capture on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= ST_CLEAN;
            byte_q <= '0;
            bit_q  <= '0;
        end else if (load) begin
            kind_q <= kind_in;
            byte_q <= byte_in;
            bit_q  <= bit_in;
        end
    end
endmodule

// File: rtl/ecc1_check.sv
// ecc1_check: top of the single-bit NAND ECC checker.
// Compares a stored and a recomputed code on a strobe, reports the outcome
// one clock later, and offers a combinational raw-to-code packing path.
// Assumes the caller holds the codes valid during the strobe cycle.
module ecc1_check
    import ecc1_pkg::*;
#(
    parameter int HALF_W      = 12,
    parameter int CHUNK_BYTES = 512,
    parameter int RAW_W       = 32,
    parameter int HI_LSB      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [2*HALF_W-1:0]    stored_code,
    input  logic [2*HALF_W-1:0]    calc_code,
    input  logic [RAW_W-1:0]       raw_parity,
    output logic [2*HALF_W-1:0]    packed_code,
    output logic                   out_valid,
    output logic [1:0]             status,
    output logic [HALF_W-4:0]      err_byte,
    output logic [2:0]             err_bit
);
    localparam int CODE_W = 2 * HALF_W;
    localparam int BYTE_W = HALF_W - 3;

    logic [CODE_W-1:0] diff;
    ecc1_status_e      kind_c;
    ecc1_status_e      kind_r;
    logic [BYTE_W-1:0] byte_c;
    logic [2:0]        bit_c;

    // Difference between stored and recomputed code.
    always_comb diff = stored_code ^ calc_code;

    ecc1_pack #(.HALF_W(HALF_W), .RAW_W(RAW_W), .HI_LSB(HI_LSB)) u_pack (
        .raw  (raw_parity),
        .code (packed_code)
    );

    ecc1_classify #(.HALF_W(HALF_W), .CHUNK_BYTES(CHUNK_BYTES)) u_cls (
        .diff     (diff),
        .kind     (kind_c),
        .byte_idx (byte_c),
        .bit_idx  (bit_c)
    );

    ecc1_result_reg #(.BYTE_W(BYTE_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .kind_in (kind_c),
        .byte_in (byte_c),
        .bit_in  (bit_c),
        .valid_q (out_valid),
        .kind_q  (kind_r),
        .byte_q  (err_byte),
        .bit_q   (err_bit)
    );

    // Status bus carries the enum encoding.
    always_comb status = kind_r;
endmodule

// File: rtl/ecc1_check_sva.sv
// ecc1_check_sva: protocol and outcome properties of ecc1_check, bound in.
module ecc1_check_sva #(
    parameter int HALF_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2*HALF_W-1:0] stored_code,
    input logic [2*HALF_W-1:0] calc_code,
    input logic                out_valid,
    input logic [1:0]          status,
    input logic [HALF_W-4:0]   err_byte,
    input logic [2:0]          err_bit
);
    a_r7_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r7_no_pulse_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r8_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

    a_r2_equal_codes_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stored_code == calc_code) |=> (status == 2'd0));

    a_r5_single_bit_diff: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $countones(stored_code ^ calc_code) == 1) |=> (status == 2'd2));

    a_r10_positions_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd1) |-> (err_byte == '0 && err_bit == '0));
endmodule

bind ecc1_check ecc1_check_sva #(.HALF_W(HALF_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .stored_code (stored_code),
    .calc_code   (calc_code),
    .out_valid   (out_valid),
    .status      (status),
    .err_byte    (err_byte),
    .err_bit     (err_bit)
);

// File: tb/test_ecc1_check.sv
// test_ecc1_check: sweeps every locating pattern, single-bit and two-bit
// difference, plus packing, hold and reset behaviour.
module test_ecc1_check;
    localparam int HALF_W = 12;
    localparam int CHUNK  = 384;
    localparam int CW     = 2 * HALF_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [CW-1:0] stored_code = '0;
    logic [CW-1:0] calc_code = '0;
    logic [31:0]   raw_parity = '0;
    logic [CW-1:0] packed_code;
    logic          out_valid;
    logic [1:0]    status;
    logic [8:0]    err_byte;
    logic [2:0]    err_bit;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    ecc1_check #(.HALF_W(HALF_W), .CHUNK_BYTES(CHUNK)) i_ecc1_check (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .stored_code(stored_code), .calc_code(calc_code),
        .raw_parity(raw_parity), .packed_code(packed_code),
        .out_valid(out_valid), .status(status),
        .err_byte(err_byte), .err_bit(err_bit)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply one comparison; check result, then check pulse end and hold.
    task automatic run_case(input logic [CW-1:0] base, input logic [CW-1:0] d,
                            input int exp_st, input int exp_byte, input int exp_bit,
                            input string tag);
        @(negedge clk);
        calc_code   = base;
        stored_code = base ^ d;
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, {tag, " R7 valid"}, out_valid, 1);
        check(status == exp_st[1:0], {tag, " status"}, status, exp_st);
        check(err_byte == exp_byte[8:0] && err_bit == exp_bit[2:0], {tag, " R10 position"},
              {err_byte, err_bit}, (exp_byte << 3) | exp_bit);
        stored_code = ~stored_code;
        calc_code   = calc_code + 24'h1234;
        @(negedge clk);
        check(out_valid == 1'b0, {tag, " R7 pulse end"}, out_valid, 0);
        check(status == exp_st[1:0] && err_byte == exp_byte[8:0], {tag, " R8 hold"},
              status, exp_st);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] base;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && status == 0 && err_byte == 0 && err_bit == 0,
              "R9 reset state", status, 0);
        rst_n = 1'b1;

        // R1: packing helper.
        for (int k = 0; k < 40; k++) begin
            logic [31:0] r;
            r = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : $urandom;
            @(negedge clk);
            raw_parity = r;
            #1;
            check(packed_code == ~{r[27:16], r[11:0]}, "R1 pack", packed_code,
                  ~{r[27:16], r[11:0]});
        end

        // R2: equal codes.
        for (int k = 0; k < 16; k++) begin
            base = CW'($urandom);
            run_case(base, '0, 0, 0, 0, "R2 clean");
        end

        // R3/R4: every locating pattern.
        for (int b = 0; b < 512; b++) begin
            for (int t = 0; t < 8; t++) begin
                logic [HALF_W-1:0] hi;
                hi   = HALF_W'((b << 3) | t);
                base = CW'($urandom);
                if (b < CHUNK)
                    run_case(base, {hi, ~hi}, 1, b, t, "R3 locate");
                else
                    run_case(base, {hi, ~hi}, 3, 0, 0, "R4 out of range");
            end
        end

        // R5: single-bit differences.
        for (int k = 0; k < CW; k++) begin
            base = CW'($urandom);
            run_case(base, CW'(1) << k, 2, 0, 0, "R5 code only");
        end

        // R6: two-bit differences.
        for (int i = 0; i < CW; i++) begin
            for (int j = i + 1; j < CW; j++) begin
                base = CW'($urandom);
                run_case(base, (CW'(1) << i) | (CW'(1) << j), 3, 0, 0, "R6 double");
            end
        end
        run_case(24'h0, 24'hFFFFFF, 3, 0, 0, "R6 all ones");

        // R9: reset after a located result.
        run_case(24'h0, {12'h005, ~12'h005}, 1, 0, 5, "R3 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(out_valid == 0 && status == 0 && err_byte == 0 && err_bit == 0,
              "R9 cleared", {status, err_byte, err_bit}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule